// File: doc/BRIEF.md
# Flow-Through Burst Synchronous SRAM

This block is a small single-port synchronous memory with four 9-bit byte lanes. Address, control and write data are sampled on the rising clock edge. The read path has no output register: once an edge has captured a read address, the stored word drives `dout` before the next edge. A 2-bit sequencer produces up to four word addresses from one captured address. The sequence is linear or interleaved, and it can be held on the same word.

A cycle can begin with one of two load strobes. The controller strobe `ctl_ld_n` loads an address on its own and may start a read or a write. The processor strobe `cpu_ld_n` loads only while `en_n` is low, and it always starts a read. A cycle with no accepted strobe is a continuation cycle. `step_n` low moves to the next word of the sequence, and `step_n` high stays on the current word. Writes follow a fixed precedence: the global write `all_wr_n` comes first, then the lane-write gate `lane_wr_n`, then the per-lane selects. The sleep input freezes all internal state. The bidirectional data bus is split into `din`, `dout` and the drive enable `dout_en`.

Top module: `fts_burst_sram`

## Requirements
- R1: When an edge captures a read, `dout` shows the stored word for that edge's address after the edge and before the next one. `dout_en` is 1 if the chip is selected and `rd_drive_n` is low.
- R2: An address loads at an edge when `ctl_ld_n` is low, or when `cpu_ld_n` is low and `en_n` is low. If `cpu_ld_n` is low while `en_n` is high, and `ctl_ld_n` is high, the edge is a continuation cycle. The captured address does not change.
- R3: The chip is selected only when `en_n`=0, `sel_p`=1 and `sel_n`=0. A load edge without selection ends the access. `dout_en` goes to 0, and continuation cycles after it write nothing.
- R4: `all_wr_n` low in a write-capable cycle writes all four lanes, whatever `lane_wr_n` and `lane_sel_n` are.
- R5: With `lane_wr_n` high, `lane_sel_n` is ignored. With `lane_wr_n` low, each low bit `lane_sel_n[i]` writes lane i, and several lanes may be written in one cycle. Lane i is `din`/`dout` bits 9i+8 down to 9i.
- R6: An edge that writes any lane leaves `dout_en` at 0 until the next edge.
- R7: `rd_drive_n` high forces `dout_en` to 0 at once, with no clock edge needed.
- R8: Word k of a sequence (k = 0..3, wrapping after 3) keeps the upper address bits of the start address. Its low two bits are (start + k) mod 4 when `interleave`=0, and start XOR k when `interleave`=1. This holds for reads and for writes.
- R9: In a continuation cycle with `step_n` high, the same word is accessed again. A read repeats the same data, and a write goes to the same word.
- R10: A cycle loaded by `cpu_ld_n` is a read, even if write inputs are active. Memory is unchanged and `dout_en` is 1.
- R11: While `sleep` is 1, no edge changes the stored data or the access state, and `dout_en` is 0.
- R12: After reset, no access is active and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of access state |
| sleep | input | 1 | Freezes internal state; data retained |
| en_n | input | 1 | Active-low chip enable; also gates `cpu_ld_n` |
| sel_p | input | 1 | Active-high chip select |
| sel_n | input | 1 | Active-low chip select |
| cpu_ld_n | input | 1 | Processor load strobe, read-only start |
| ctl_ld_n | input | 1 | Controller load strobe, read or write start |
| step_n | input | 1 | Low: advance sequence; high: hold word |
| all_wr_n | input | 1 | Global write of all lanes |
| lane_wr_n | input | 1 | Gate for the per-lane selects |
| lane_sel_n | input | 4 | Per-lane write selects, bit i = lane i |
| interleave | input | 1 | 1: XOR sequence; 0: linear sequence |
| rd_drive_n | input | 1 | Asynchronous output drive disable |
| addr | input | ADDR_W | Word address |
| din | input | 36 | Write data |
| dout | output | 36 | Flow-through read data |
| dout_en | output | 1 | Bus drive enable for `dout` |

## Verification
The properties assume a few things about how the block is used. `interleave` stays fixed for the whole run. After `sleep` is released, a deselecting load edge comes before any access. A word is only read while the output is driven if it was written earlier, so `dout` never carries undefined data when a hold cycle is checked. The directed tests change every input one time unit after a rising edge and sample one time unit after it. They set `interleave` only between sequences, follow each sleep with a deselect, and read back only words the test has already written.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    CK_HOLD,
    CK_DESEL,
    CK_RD_NEW,
    CK_WR_NEW,
    CK_CONT
  } cyc_kind_e;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq (
  input  logic [1:0] start_lo,
  input  logic [1:0] step,
  input  logic       interleave,
  output logic [1:0] seq_lo
);
  // XOR order for interleaved mode, modulo-4 add for linear mode
  assign seq_lo = interleave ? (start_lo ^ step) : (start_lo + step);
endmodule

// File: rtl/fts_lane_bank.sv
module fts_lane_bank #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [LANE_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  // unregistered read path
  assign rd = mem[ra];
endmodule

// File: rtl/fts_cycle_ctrl.sv
module fts_cycle_ctrl
  import fts_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              en_n,
  input  logic              sel_p,
  input  logic              sel_n,
  input  logic              cpu_ld_n,
  input  logic              ctl_ld_n,
  input  logic              step_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LANES-1:0]  wr_lanes,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_ok
);
  logic              chip_sel, cpu_load, ctl_load;
  logic [LANES-1:0]  lane_req;
  cyc_kind_e         kind;
  logic              active_q, wr_cyc_q;
  logic [ADDR_W-1:0] base_q, cur_q, eff_addr;
  logic [1:0]        step_q, step_nxt, seq_lo;

  assign chip_sel = !en_n && sel_p && !sel_n;
  assign cpu_load = !cpu_ld_n && !en_n;
  assign ctl_load = !ctl_ld_n;

  // global write wins, then the lane gate, then the lane selects
  always_comb begin
    if (!all_wr_n)       lane_req = '1;
    else if (!lane_wr_n) lane_req = ~lane_sel_n;
    else                 lane_req = '0;
  end

  always_comb begin
    if (sleep)                      kind = CK_HOLD;
    else if (cpu_load || ctl_load) begin
      if (!chip_sel)                kind = CK_DESEL;
      else if (cpu_load)            kind = CK_RD_NEW;
      else if (|lane_req)           kind = CK_WR_NEW;
      else                          kind = CK_RD_NEW;
    end else                        kind = CK_CONT;
  end

  assign step_nxt = step_n ? step_q : step_q + 2'd1;

  fts_burst_seq u_seq (
    .start_lo   (base_q[1:0]),
    .step       (step_nxt),
    .interleave (interleave),
    .seq_lo     (seq_lo)
  );

  always_comb begin
    if (kind == CK_RD_NEW || kind == CK_WR_NEW) eff_addr = addr;
    else                                         eff_addr = {base_q[ADDR_W-1:2], seq_lo};
  end

  assign wr_addr  = eff_addr;
  assign wr_lanes = (kind == CK_WR_NEW || (kind == CK_CONT && active_q)) ? lane_req : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      wr_cyc_q <= 1'b0;
      base_q   <= '0;
      cur_q    <= '0;
      step_q   <= '0;
    end else begin
      unique case (kind)
        CK_HOLD: ;
        CK_DESEL: begin
          active_q <= 1'b0;
          wr_cyc_q <= 1'b0;
        end
        CK_RD_NEW, CK_WR_NEW: begin
          active_q <= 1'b1;
          base_q   <= addr;
          cur_q    <= addr;
          step_q   <= '0;
          wr_cyc_q <= (kind == CK_WR_NEW);
        end
        CK_CONT: begin
          if (active_q) begin
            step_q   <= step_nxt;
            cur_q    <= eff_addr;
            wr_cyc_q <= |lane_req;
          end
        end
        default: ;
      endcase
    end
  end

  assign rd_addr = cur_q;
  assign out_ok  = active_q && !wr_cyc_q;
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              en_n,
  input  logic              sel_p,
  input  logic              sel_n,
  input  logic              cpu_ld_n,
  input  logic              ctl_ld_n,
  input  logic              step_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              interleave,
  input  logic              rd_drive_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [LANES-1:0]  wr_lanes;
  logic              out_ok;

  fts_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep      (sleep),
    .en_n       (en_n),
    .sel_p      (sel_p),
    .sel_n      (sel_n),
    .cpu_ld_n   (cpu_ld_n),
    .ctl_ld_n   (ctl_ld_n),
    .step_n     (step_n),
    .all_wr_n   (all_wr_n),
    .lane_wr_n  (lane_wr_n),
    .lane_sel_n (lane_sel_n),
    .interleave (interleave),
    .addr       (addr),
    .wr_addr    (wr_addr),
    .wr_lanes   (wr_lanes),
    .rd_addr    (rd_addr),
    .out_ok     (out_ok)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fts_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk (clk),
      .we  (wr_lanes[g]),
      .wa  (wr_addr),
      .wd  (din[g*LANE_W +: LANE_W]),
      .ra  (rd_addr),
      .rd  (dout[g*LANE_W +: LANE_W])
    );
  end

  // asynchronous drive control
  assign dout_en = out_ok && !rd_drive_n && !sleep;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep,
  input logic              en_n,
  input logic              sel_p,
  input logic              sel_n,
  input logic              cpu_ld_n,
  input logic              ctl_ld_n,
  input logic              step_n,
  input logic              all_wr_n,
  input logic              lane_wr_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              rd_drive_n,
  input logic [DATA_W-1:0] dout,
  input logic              dout_en
);
  logic chip_on, any_load, wr_ask;
  assign chip_on  = !en_n && sel_p && !sel_n;
  assign any_load = !ctl_ld_n || (!cpu_ld_n && !en_n);
  assign wr_ask   = !all_wr_n || (!lane_wr_n && (lane_sel_n != '1));

  p_drive_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drive_n |-> !dout_en);

  p_sleep_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !ctl_ld_n && cpu_ld_n && chip_on && !all_wr_n) |=> !dout_en);

  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && any_load && !chip_on) |=> !dout_en);

  p_cpu_reads_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !cpu_ld_n && chip_on) |=> (dout_en || rd_drive_n || sleep));

  p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && !any_load && step_n && !wr_ask && dout_en) |=> $stable(dout));
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.LANES(LANES), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/fts_burst_sram_test.sv
`timescale 1ns/1ps
module fts_burst_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n, sleep, en_n, sel_p, sel_n, cpu_ld_n, ctl_ld_n, step_n;
  logic all_wr_n, lane_wr_n, interleave, rd_drive_n;
  logic [3:0]    lane_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  logic [DW-1:0] ref_mem [64];
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  fts_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .en_n(en_n), .sel_p(sel_p),
    .sel_n(sel_n), .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .step_n(step_n),
    .all_wr_n(all_wr_n), .lane_wr_n(lane_wr_n), .lane_sel_n(lane_sel_n),
    .interleave(interleave), .rd_drive_n(rd_drive_n), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    sleep = 0; en_n = 1; sel_p = 0; sel_n = 1; cpu_ld_n = 1; ctl_ld_n = 1;
    step_n = 1; all_wr_n = 1; lane_wr_n = 1; lane_sel_n = 4'hF;
    rd_drive_n = 0; addr = '0; din = '0;
  endtask

  task automatic sel_on();
    en_n = 0; sel_p = 1; sel_n = 0;
  endtask

  task automatic wr_one(input logic [AW-1:0] a, input logic [DW-1:0] d);
    idle(); sel_on(); ctl_ld_n = 0; addr = a; din = d; all_wr_n = 0;
    tick();
    ref_mem[a] = d;
    check("R6 write cycle not driven", {35'd0, dout_en}, 36'd0);
    idle();
  endtask

  task automatic rd_one(input logic [AW-1:0] a, input string req);
    idle(); sel_on(); ctl_ld_n = 0; addr = a;
    tick();
    check(req, dout, ref_mem[a]);
    check("R1 read drives bus", {35'd0, dout_en}, 36'd1);
    idle();
  endtask

  task automatic t_reset();
    idle(); interleave = 0; rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
    check("R12 dout_en after reset", {35'd0, dout_en}, 36'd0);
  endtask

  task automatic t_global();
    for (int i = 0; i < 4; i++) wr_one(AW'(8 + i), 36'hA_0000_0000 | 36'(i * 36'h1_0101));
    for (int i = 3; i >= 0; i--) rd_one(AW'(8 + i), "R1 flow-through read");
    // priority: global write over lane gate and selects
    idle(); sel_on(); ctl_ld_n = 0; addr = 6'd9; din = 36'h5_A5A5_A5A5;
    all_wr_n = 0; lane_wr_n = 0; lane_sel_n = 4'b1110;
    tick(); ref_mem[9] = 36'h5_A5A5_A5A5;
    rd_one(6'd9, "R4 global write covers all lanes");
  endtask

  task automatic t_lanes();
    logic [DW-1:0] nd, ex;
    nd = 36'hF_EDCB_A987; ex = ref_mem[8];
    idle(); sel_on(); ctl_ld_n = 0; addr = 6'd8; din = nd;
    lane_wr_n = 0; lane_sel_n = 4'b1010;
    tick();
    check("R6 lane write not driven", {35'd0, dout_en}, 36'd0);
    for (int i = 0; i < 4; i++) if (i == 0 || i == 2) ex[9*i +: 9] = nd[9*i +: 9];
    ref_mem[8] = ex;
    rd_one(6'd8, "R5 lanes 0 and 2 written");
    // selects ignored while lane gate high
    idle(); sel_on(); ctl_ld_n = 0; addr = 6'd10; din = 36'h0; lane_sel_n = 4'h0;
    tick();
    check("R5 gated selects ignored", dout, ref_mem[10]);
    check("R5 gated cycle is read", {35'd0, dout_en}, 36'd1);
  endtask

  task automatic t_cpu();
    rd_one(6'd8, "R1 read before cpu load");
    idle(); sel_on(); cpu_ld_n = 0; addr = 6'd11; all_wr_n = 0; din = 36'h0_DEAD_BEEF;
    tick();
    check("R10 cpu load reads", dout, ref_mem[11]);
    check("R10 cpu load drives", {35'd0, dout_en}, 36'd1);
    // cpu strobe without enable: continuation, address kept
    idle(); cpu_ld_n = 0; en_n = 1; addr = 6'd8;
    tick();
    check("R2 gated cpu strobe keeps address", dout, ref_mem[11]);
    rd_one(6'd11, "R10 memory unchanged");
  endtask

  task automatic t_desel();
    rd_one(6'd10, "R1 read before deselect");
    idle(); en_n = 0; sel_p = 0; sel_n = 0; ctl_ld_n = 0; addr = 6'd10;
    tick();
    check("R3 deselect floats bus", {35'd0, dout_en}, 36'd0);
    idle(); all_wr_n = 0; step_n = 0; din = 36'h1_1111_1111;
    tick();
    check("R3 no access after deselect", {35'd0, dout_en}, 36'd0);
    idle(); all_wr_n = 0; step_n = 1; din = 36'h2_2222_2222;
    tick();
    rd_one(6'd10, "R3 word kept after deselect");
    rd_one(6'd11, "R3 next word kept");
  endtask

  task automatic t_seq(input logic ilv, input logic [AW-1:0] start);
    logic [AW-1:0] ea;
    for (int i = 0; i < 4; i++) wr_one({start[AW-1:2], 2'(i)}, 36'h3_0000_0000 | 36'(start * 16 + i));
    idle(); interleave = ilv;
    rd_one(start, "R8 first word");
    for (int k = 1; k <= 4; k++) begin
      idle(); step_n = 0;
      tick();
      ea = {start[AW-1:2], ilv ? (start[1:0] ^ 2'(k)) : (start[1:0] + 2'(k))};
      check(ilv ? "R8 interleaved word" : "R8 linear word", dout, ref_mem[ea]);
    end
    idle();
  endtask

  task automatic t_seq_write();
    interleave = 0;
    idle(); sel_on(); ctl_ld_n = 0; addr = 6'h21; all_wr_n = 0; din = 36'h4_0000_0021;
    tick(); ref_mem[6'h21] = din;
    for (int k = 1; k <= 3; k++) begin
      idle(); all_wr_n = 0; step_n = 0; din = 36'h4_0000_0100 + 36'(k);
      tick();
      ref_mem[{4'h8, 2'(1 + k)}] = din;
      check("R6 sequence write not driven", {35'd0, dout_en}, 36'd0);
    end
    idle(); all_wr_n = 0; step_n = 1; din = 36'h4_0000_0999;
    tick(); ref_mem[6'h20] = din;
    for (int i = 0; i < 4; i++) rd_one(AW'(32 + i), "R8 R9 sequence write placement");
  endtask

  task automatic t_hold();
    interleave = 0;
    rd_one(6'h10, "R9 hold start");
    for (int k = 0; k < 2; k++) begin
      idle(); step_n = 1;
      tick();
      check("R9 held read repeats", dout, ref_mem[6'h10]);
    end
    idle(); step_n = 0;
    tick();
    check("R9 advance after hold", dout, ref_mem[6'h11]);
    idle();
  endtask

  task automatic t_drive();
    rd_one(6'h12, "R7 read before drive test");
    rd_drive_n = 1; #1;
    check("R7 drive off without clock", {35'd0, dout_en}, 36'd0);
    rd_drive_n = 0; #1;
    check("R7 drive back on", {35'd0, dout_en}, 36'd1);
  endtask

  task automatic t_sleep();
    rd_one(6'h13, "R11 read before sleep");
    idle(); sleep = 1; sel_on(); ctl_ld_n = 0; addr = 6'h13; all_wr_n = 0; din = 36'h7_7777_7777;
    tick();
    check("R11 sleep floats bus", {35'd0, dout_en}, 36'd0);
    idle(); sleep = 1; step_n = 0; all_wr_n = 0; din = 36'h6_6666_6666;
    tick();
    idle(); ctl_ld_n = 0; en_n = 1;
    tick();
    rd_one(6'h13, "R11 data kept through sleep");
  endtask

  initial begin
    t_reset();
    t_global();
    t_lanes();
    t_cpu();
    t_desel();
    t_seq(1'b0, 6'h12);
    t_seq(1'b1, 6'h15);
    t_seq_write();
    t_hold();
    t_drive();
    t_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule